// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for each ALU operand of the instruction currently in the execute stage of a five-stage in-order integer pipeline, where that operand's value should come from. It looks at the source register numbers held in the decode/execute pipeline register. It compares them against the destination register number and write-enable of the two older instructions still in flight: the one in the execute/memory register and the one in the memory/writeback register. When a younger source names a register that an older instruction is about to write, the stale register-file value is replaced by the in-flight result.

The block also contains the operand multiplexers. Each multiplexer picks between the register-file read value, the execute/memory result and the memory/writeback result. The memory/writeback result input is expected to carry load data as well as computational results, because a loaded value only exists once the memory stage has finished. Holding the pipeline on a load-use pair is handled elsewhere. The whole block is combinational, so its select codes and operand values follow the inputs within the same cycle.

Top module: `fwd_unit`

## Requirements
- R1: When neither later stage matches a source register, that operand's select is 2'b00 and the operand output equals its register-file input.
- R2: When the execute/memory destination equals a source register, its write-enable is 1 and the register number is not 0, that operand's select is 2'b10 and the operand output equals the execute/memory result.
- R3: When only the memory/writeback destination matches a source register (write-enable 1, register number not 0), that operand's select is 2'b01 and the operand output equals the memory/writeback result.
- R4: When both stages match the same source register, the execute/memory stage wins (select 2'b10), since it holds the newer value.
- R5: A stage whose write-enable is 0 never causes forwarding, whatever its destination number.
- R6: A source register number of 0 always selects the register file (select 2'b00), even if a stage with write-enable 1 names register 0.
- R7: Each operand is resolved on its own: the two operands may take different sources, or both take the same one, in the same cycle.
- R8: The select code 2'b11 never appears on any operand. Operand 0's code sits in op_sel[1:0] and operand 1's in op_sel[3:2].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_idx | input | NUM_SRC*REG_AW | Source register numbers of the execute-stage instruction; operand k at bits [k*REG_AW +: REG_AW] |
| rf_data | input | NUM_SRC*XLEN | Register-file read values, operand k at [k*XLEN +: XLEN] |
| exm_dst_idx | input | REG_AW | Destination register number in the execute/memory register |
| exm_wr_en | input | 1 | Register-write enable of the execute/memory instruction |
| exm_result | input | XLEN | ALU result held in the execute/memory register |
| mwb_dst_idx | input | REG_AW | Destination register number in the memory/writeback register |
| mwb_wr_en | input | 1 | Register-write enable of the memory/writeback instruction |
| mwb_result | input | XLEN | Value being written back (ALU or load data) |
| op_sel | output | 2*NUM_SRC | Per-operand select code: 00 register file, 10 execute/memory, 01 memory/writeback |
| op_data | output | NUM_SRC*XLEN | Selected operand values, operand k at [k*XLEN +: XLEN] |

## Verification
No register lies between any input and any output, so every select code and operand value is due in the same cycle as the stimulus that causes it. The bench changes inputs on the falling clock edge and samples a quarter period later, well before the next rising edge. Each check therefore reads values settled from that one stimulus and never from the previous or next one. A sweep over small register numbers compares the selects against a priority rule computed in the bench.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MWB = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_idx,
  input  logic [REG_AW-1:0] dst_idx,
  input  logic              dst_we,
  output logic              hit
);

  localparam logic [REG_AW-1:0] ZERO_IDX = '0;

  logic same_reg;
  logic live_dst;

  always_comb begin
    same_reg = (dst_idx == src_idx);
    live_dst = dst_we && (dst_idx != ZERO_IDX);
    hit      = same_reg && live_dst;
  end

endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
  import fwd_pkg::*;
(
  input  logic     hit_exm,
  input  logic     hit_mwb,
  output fwd_sel_e sel
);

  always_comb begin
    if (hit_exm)      sel = FWD_EXM;
    else if (hit_mwb) sel = FWD_MWB;
    else              sel = FWD_RF;
  end

endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  fwd_sel_e          sel,
  input  logic [XLEN-1:0]   rf_val,
  input  logic [XLEN-1:0]   exm_val,
  input  logic [XLEN-1:0]   mwb_val,
  output logic [XLEN-1:0]   op_val
);

  always_comb begin
    case (sel)
      FWD_EXM: op_val = exm_val;
      FWD_MWB: op_val = mwb_val;
      default: op_val = rf_val;
    endcase
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int XLEN    = 32,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC*REG_AW-1:0] ex_src_idx,
  input  logic [NUM_SRC*XLEN-1:0]   rf_data,
  input  logic [REG_AW-1:0]         exm_dst_idx,
  input  logic                      exm_wr_en,
  input  logic [XLEN-1:0]           exm_result,
  input  logic [REG_AW-1:0]         mwb_dst_idx,
  input  logic                      mwb_wr_en,
  input  logic [XLEN-1:0]           mwb_result,
  output logic [2*NUM_SRC-1:0]      op_sel,
  output logic [NUM_SRC*XLEN-1:0]   op_data
);

  localparam int SEL_W = 2;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    logic     hit_exm;
    logic     hit_mwb;
    fwd_sel_e sel;

    fwd_match #(.REG_AW(REG_AW)) u_match_exm (
      .src_idx (ex_src_idx[g*REG_AW +: REG_AW]),
      .dst_idx (exm_dst_idx),
      .dst_we  (exm_wr_en),
      .hit     (hit_exm)
    );

    fwd_match #(.REG_AW(REG_AW)) u_match_mwb (
      .src_idx (ex_src_idx[g*REG_AW +: REG_AW]),
      .dst_idx (mwb_dst_idx),
      .dst_we  (mwb_wr_en),
      .hit     (hit_mwb)
    );

    fwd_prio u_prio (
      .hit_exm (hit_exm),
      .hit_mwb (hit_mwb),
      .sel     (sel)
    );

    fwd_mux #(.XLEN(XLEN)) u_mux (
      .sel     (sel),
      .rf_val  (rf_data[g*XLEN +: XLEN]),
      .exm_val (exm_result),
      .mwb_val (mwb_result),
      .op_val  (op_data[g*XLEN +: XLEN])
    );

    assign op_sel[g*SEL_W +: SEL_W] = sel;
  end

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_AW  = 5,
  parameter int XLEN    = 32,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC*REG_AW-1:0] ex_src_idx,
  input  logic [NUM_SRC*XLEN-1:0]   rf_data,
  input  logic [REG_AW-1:0]         exm_dst_idx,
  input  logic                      exm_wr_en,
  input  logic [XLEN-1:0]           exm_result,
  input  logic [REG_AW-1:0]         mwb_dst_idx,
  input  logic                      mwb_wr_en,
  input  logic [XLEN-1:0]           mwb_result,
  input  logic [2*NUM_SRC-1:0]      op_sel,
  input  logic [NUM_SRC*XLEN-1:0]   op_data
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    logic [REG_AW-1:0] src;
    logic [1:0]        sel;
    logic [XLEN-1:0]   rf_v;
    logic [XLEN-1:0]   op_v;

    assign src  = ex_src_idx[g*REG_AW +: REG_AW];
    assign sel  = op_sel[2*g +: 2];
    assign rf_v = rf_data[g*XLEN +: XLEN];
    assign op_v = op_data[g*XLEN +: XLEN];

    always_comb begin
      // R8
      sel_legal_chk: assert (sel != 2'b11);
      // R6
      zero_src_chk: assert (src != '0 || sel == 2'b00);
      // R4
      exm_prio_chk: assert (!(exm_wr_en && exm_dst_idx != '0 && exm_dst_idx == src) || sel == 2'b10);
      // R5
      no_we_chk: assert (exm_wr_en || mwb_wr_en || sel == 2'b00);
      // R1
      rf_path_chk: assert (sel != 2'b00 || op_v == rf_v);
      // R2
      exm_path_chk: assert (sel != 2'b10 || op_v == exm_result);
      // R3
      mwb_path_chk: assert (sel != 2'b01 || op_v == mwb_result);
    end
  end

endmodule

bind fwd_unit fwd_unit_chk #(
  .REG_AW  (REG_AW),
  .XLEN    (XLEN),
  .NUM_SRC (NUM_SRC)
) u_fwd_chk (
  .ex_src_idx  (ex_src_idx),
  .rf_data     (rf_data),
  .exm_dst_idx (exm_dst_idx),
  .exm_wr_en   (exm_wr_en),
  .exm_result  (exm_result),
  .mwb_dst_idx (mwb_dst_idx),
  .mwb_wr_en   (mwb_wr_en),
  .mwb_result  (mwb_result),
  .op_sel      (op_sel),
  .op_data     (op_data)
);

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;

  localparam int AW = 5;
  localparam int XW = 32;
  localparam int NS = 2;
  localparam logic [XW-1:0] RF0 = 32'h1111_0001;
  localparam logic [XW-1:0] RF1 = 32'h2222_0002;
  localparam logic [XW-1:0] EXV = 32'hE0E0_0003;
  localparam logic [XW-1:0] MWV = 32'hB0B0_0004;

  // fields: {src0, src1, exm_dst, exm_we, mwb_dst, mwb_we, exp_sel0, exp_sel1}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {5'd1,  5'd2,  5'd0,  1'b0, 5'd0,  1'b0, 2'b00, 2'b00},  // R1
    {5'd3,  5'd4,  5'd3,  1'b1, 5'd0,  1'b0, 2'b10, 2'b00},  // R2
    {5'd3,  5'd4,  5'd0,  1'b0, 5'd4,  1'b1, 2'b00, 2'b01},  // R3
    {5'd5,  5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 2'b10, 2'b10},  // R4
    {5'd6,  5'd7,  5'd6,  1'b0, 5'd6,  1'b1, 2'b01, 2'b00},  // R5
    {5'd6,  5'd7,  5'd6,  1'b0, 5'd7,  1'b0, 2'b00, 2'b00},  // R5
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00},  // R6
    {5'd9,  5'd9,  5'd9,  1'b1, 5'd0,  1'b1, 2'b10, 2'b10},  // R7
    {5'd10, 5'd11, 5'd11, 1'b1, 5'd10, 1'b1, 2'b01, 2'b10},  // R7
    {5'd31, 5'd1,  5'd31, 1'b1, 5'd1,  1'b1, 2'b10, 2'b01}   // R3
  };

  logic clk;
  logic rst_n;
  logic [NS*AW-1:0] ex_src_idx;
  logic [NS*XW-1:0] rf_data;
  logic [AW-1:0]    exm_dst_idx;
  logic             exm_wr_en;
  logic [XW-1:0]    exm_result;
  logic [AW-1:0]    mwb_dst_idx;
  logic             mwb_wr_en;
  logic [XW-1:0]    mwb_result;
  logic [2*NS-1:0]  op_sel;
  logic [NS*XW-1:0] op_data;

  int n_chk;
  int n_fail;
  bit done;

  fwd_unit dut (
    .ex_src_idx  (ex_src_idx),
    .rf_data     (rf_data),
    .exm_dst_idx (exm_dst_idx),
    .exm_wr_en   (exm_wr_en),
    .exm_result  (exm_result),
    .mwb_dst_idx (mwb_dst_idx),
    .mwb_wr_en   (mwb_wr_en),
    .mwb_result  (mwb_result),
    .op_sel      (op_sel),
    .op_data     (op_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [XW-1:0] act,
                       input logic [XW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [XW-1:0] pick(input logic [1:0] s, input logic [XW-1:0] rf);
    case (s)
      2'b10:   return EXV;
      2'b01:   return MWV;
      default: return rf;
    endcase
  endfunction

  function automatic logic [1:0] model(input logic [AW-1:0] src, input logic [AW-1:0] ed,
                                       input logic ew, input logic [AW-1:0] md, input logic mw);
    if (src != 0 && ew && ed == src) return 2'b10;
    if (src != 0 && mw && md == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic apply(input logic [AW-1:0] s0, input logic [AW-1:0] s1,
                       input logic [AW-1:0] ed, input logic ew,
                       input logic [AW-1:0] md, input logic mw);
    @(negedge clk);
    ex_src_idx  = {s1, s0};
    exm_dst_idx = ed;
    exm_wr_en   = ew;
    mwb_dst_idx = md;
    mwb_wr_en   = mw;
    #5;
  endtask

  initial begin
    rst_n = 1'b0;
    ex_src_idx = '0; rf_data = {RF1, RF0};
    exm_dst_idx = '0; exm_wr_en = 1'b0; exm_result = EXV;
    mwb_dst_idx = '0; mwb_wr_en = 1'b0; mwb_result = MWV;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    // R1: idle state after reset selects the register file
    check(op_sel == 4'b0000, "R1 idle sel", {28'd0, op_sel}, 32'd0);
    check(op_data == {RF1, RF0}, "R1 idle data", op_data[XW-1:0], RF0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      apply(v[25:21], v[20:16], v[15:11], v[10], v[9:5], v[4]);
      check(op_sel[1:0] == v[3:2], "R1-table sel0 (R2 R3 R4 R5 R6 R7)",
            {30'd0, op_sel[1:0]}, {30'd0, v[3:2]});
      check(op_sel[3:2] == v[1:0], "R7 table sel1",
            {30'd0, op_sel[3:2]}, {30'd0, v[1:0]});
      check(op_data[XW-1:0] == pick(v[3:2], RF0), "R2 R3 data0",
            op_data[XW-1:0], pick(v[3:2], RF0));
      check(op_data[2*XW-1:XW] == pick(v[1:0], RF1), "R2 R3 data1",
            op_data[2*XW-1:XW], pick(v[1:0], RF1));
    end

    // R2: forwarded value follows a changed result in the same cycle
    apply(5'd12, 5'd13, 5'd12, 1'b1, 5'd13, 1'b1);
    exm_result = 32'hCAFE_0012;
    mwb_result = 32'hBEEF_0013;
    #2;
    check(op_data[XW-1:0] == 32'hCAFE_0012, "R2 live result", op_data[XW-1:0], 32'hCAFE_0012);
    check(op_data[2*XW-1:XW] == 32'hBEEF_0013, "R3 live result", op_data[2*XW-1:XW], 32'hBEEF_0013);
    exm_result = EXV;
    mwb_result = MWV;

    // R6: register zero named by both stages with writes enabled
    apply(5'd0, 5'd1, 5'd0, 1'b1, 5'd0, 1'b1);
    check(op_sel[1:0] == 2'b00, "R6 zero src", {30'd0, op_sel[1:0]}, 32'd0);
    check(op_data[XW-1:0] == RF0, "R6 zero data", op_data[XW-1:0], RF0);

    // R8 and R4 sweep over small register numbers against the bench rule
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 4; e++) begin
        for (int m = 0; m < 4; m++) begin
          for (int w = 0; w < 4; w++) begin
            logic [1:0] x0;
            logic [1:0] x1;
            apply(AW'(s), AW'(3 - s), AW'(e), w[0], AW'(m), w[1]);
            x0 = model(AW'(s), AW'(e), w[0], AW'(m), w[1]);
            x1 = model(AW'(3 - s), AW'(e), w[0], AW'(m), w[1]);
            check(op_sel == {x1, x0}, "R4 sweep", {28'd0, op_sel}, {28'd0, x1, x0});
            check(op_sel[1:0] != 2'b11 && op_sel[3:2] != 2'b11, "R8 no 11 code",
                  {28'd0, op_sel}, 32'd0);
          end
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule